// File: doc/BRIEF.md
# SDRAM Clock-Enable Command Gate Model

This block is a device-side behavioural model of how a synchronous DRAM treats its clock-enable input. Every clock edge it samples the clock-enable pin and the four command strobes, decides whether the command on the pins is taken or ignored, and keeps a record of which banks are open. When clock-enable drops, the block picks one of two low-power states from that record. With at least one bank open it enters clock suspend. With every bank idle it enters power-down.

The block has an internal clock enable, which is the clock-enable pin delayed by one edge. That one-edge lag applies both when the low-power state begins and when it ends. The internal enable gates command registration, the bank record and a small burst counter. During a suspend the burst counter pauses and then resumes; it is not cancelled. The block is synthesizable, so it can serve as an in-fabric checker of a controller or as an emulation stand-in for the memory's control path. Data storage, refresh and command timing checks are not part of it.

Top module: `cke_gate_model`

## Requirements
- R1: While `rst_n` is low and after its release until the first command, `mode` is 2'b00, `bank_open` is all zero, `int_clk_en` is 1, `cmd_valid` is 0 and `burst_busy` is 0.
- R2: With `int_clk_en` high at an edge, a command with `cs_n` low is registered at that edge, and after that edge `cmd_valid` is 1 with `cmd_code` set from {`ras_n`,`cas_n`,`we_n`}: 111→0 no-op, 011→1 activate, 101→2 read, 100→3 write, 010→4 precharge, 001→5 refresh, 000→6 mode-set, 110→7 burst-stop. With `cs_n` high (deselect), `cmd_valid` is 0 after the edge.
- R3: A registered activate sets `bank_open[ba]`. A registered precharge clears `bank_open[ba]` when `pre_all` is 0, and clears every bit when `pre_all` is 1.
- R4: If `cke` is sampled low at an edge while `mode` is 2'b00, then after that edge `mode` is 2'b01 (clock suspend) if any bank is open once that edge's own command is applied, and 2'b10 (power-down) otherwise. While `cke` stays low, `mode` holds.
- R5: After every edge `int_clk_en` equals the `cke` sampled at that edge. At an edge where `int_clk_en` was low beforehand, the command on the pins is ignored: `cmd_valid` is 0 after the edge and `bank_open` does not change.
- R6: If `cke` is sampled high at an edge, `mode` is 2'b00 after that edge. A command at that same edge is still ignored when `int_clk_en` was low before it, and commands are taken again from the next edge onward.
- R7: A registered read or write sets `burst_busy` with `burst_beat` 0. Each later edge with `int_clk_en` high advances `burst_beat` by one. At the edge after the beat equal to BURST_LEN-1, `burst_busy` clears. No-op and deselect do not end a burst. A registered burst-stop clears `burst_busy`.
- R8: At an edge where `int_clk_en` was low beforehand, `burst_busy` and `burst_beat` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| pre_all | input | 1 | Precharge applies to all banks |
| cmd_valid | output | 1 | A command was registered at the last edge |
| cmd_code | output | 3 | Code of the registered command (R2) |
| int_clk_en | output | 1 | Internal clock enable, `cke` delayed one edge |
| mode | output | 2 | 00 normal, 01 clock suspend, 10 power-down |
| bank_open | output | NUM_BANKS | One bit per open bank |
| burst_busy | output | 1 | A burst is in progress |
| burst_beat | output | max(1,$clog2(BURST_LEN)) | Current beat of the burst |

## Verification
All outputs are registered. A command, a `cke` level or a burst step presented before edge n is therefore visible in `cmd_valid`, `cmd_code`, `bank_open`, `mode`, `int_clk_en` and the burst outputs just after edge n. Because of the enable lag, whether a command at edge n is taken depends on `cke` at edge n-1. The bench drives the pins one time unit after a rising edge and reads the results one time unit after the next rising edge, so every check falls exactly one edge after its stimulus. Entry and exit of suspend are each checked at the edge where the command is ignored or accepted for the first time, and burst beats are counted edge by edge across the pause.

// File: rtl/cgm_pkg.sv
package cgm_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_REF  = 3'd5,
      CMD_MRS  = 3'd6,
      CMD_BST  = 3'd7
   } cmd_e;

   typedef enum logic [1:0] {
      MODE_RUN  = 2'b00,
      MODE_SUSP = 2'b01,
      MODE_PDN  = 2'b10
   } mode_e;

   // Strobe pattern {ras_n, cas_n, we_n} to command code.
   function automatic cmd_e strobes_to_cmd(input logic [2:0] rcw);
      cmd_e c;
      case (rcw)
         3'b111:  c = CMD_NOP;
         3'b011:  c = CMD_ACT;
         3'b101:  c = CMD_RD;
         3'b100:  c = CMD_WR;
         3'b010:  c = CMD_PRE;
         3'b001:  c = CMD_REF;
         3'b000:  c = CMD_MRS;
         default: c = CMD_BST;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/cgm_cmd_decode.sv
module cgm_cmd_decode
   import cgm_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic accept,
   output logic take,
   output cmd_e code,
   output logic is_act,
   output logic is_pre,
   output logic is_rw,
   output logic is_bst
);

   assign code   = strobes_to_cmd({ras_n, cas_n, we_n});
   assign take   = accept & ~cs_n;
   assign is_act = take & (code == CMD_ACT);
   assign is_pre = take & (code == CMD_PRE);
   assign is_rw  = take & ((code == CMD_RD) | (code == CMD_WR));
   assign is_bst = take & (code == CMD_BST);

endmodule

// File: rtl/cgm_bank_track.sv
module cgm_bank_track #(
   parameter int NUM_BANKS = 4,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 is_act,
   input  logic                 is_pre,
   input  logic                 pre_all,
   input  logic [BA_W-1:0]      ba,
   output logic [NUM_BANKS-1:0] open_q,
   output logic [NUM_BANKS-1:0] open_d
);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic hit;
      assign hit = (ba == BA_W'(i));

      always_comb begin
         open_d[i] = open_q[i];
         if (is_act && hit)
            open_d[i] = 1'b1;
         else if (is_pre && (pre_all || hit))
            open_d[i] = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) open_q[i] <= 1'b0;
         else        open_q[i] <= open_d[i];
      end
   end

endmodule

// File: rtl/cgm_burst_ctr.sv
module cgm_burst_ctr #(
   parameter int BURST_LEN = 4,
   localparam int BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              start,
   input  logic              stop,
   output logic              busy,
   output logic [BEAT_W-1:0] beat
);

   localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy <= 1'b0;
      else if (start)
         busy <= 1'b1;
      else if (stop)
         busy <= 1'b0;
      else if (step_en && busy && (beat == LAST))
         busy <= 1'b0;
   end

   if (BURST_LEN > 1) begin : g_count
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            beat <= '0;
         else if (start)
            beat <= '0;
         else if (step_en && busy && (beat != LAST))
            beat <= beat + 1'b1;
      end
   end else begin : g_single
      assign beat = '0;
   end

endmodule

// File: rtl/cke_gate_model.sv
module cke_gate_model
   import cgm_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BURST_LEN = 4,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   input  logic                 pre_all,
   output logic                 cmd_valid,
   output logic [2:0]           cmd_code,
   output logic                 int_clk_en,
   output logic [1:0]           mode,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic                 burst_busy,
   output logic [BEAT_W-1:0]    burst_beat
);

   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two and at least 2");
   end
   if (BURST_LEN < 1 || BURST_LEN > 256) begin : g_bad_burst
      $error("BURST_LEN must lie in 1..256");
   end

   logic                 en_q;
   mode_e                mode_q;
   logic                 take;
   cmd_e                 code;
   logic                 is_act, is_pre, is_rw, is_bst;
   logic [NUM_BANKS-1:0] open_d;

   cgm_cmd_decode u_dec (
      .cs_n   (cs_n),
      .ras_n  (ras_n),
      .cas_n  (cas_n),
      .we_n   (we_n),
      .accept (en_q),
      .take   (take),
      .code   (code),
      .is_act (is_act),
      .is_pre (is_pre),
      .is_rw  (is_rw),
      .is_bst (is_bst)
   );

   cgm_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
      .clk     (clk),
      .rst_n   (rst_n),
      .is_act  (is_act),
      .is_pre  (is_pre),
      .pre_all (pre_all),
      .ba      (ba),
      .open_q  (bank_open),
      .open_d  (open_d)
   );

   cgm_burst_ctr #(.BURST_LEN(BURST_LEN)) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (en_q),
      .start   (is_rw),
      .stop    (is_bst),
      .busy    (burst_busy),
      .beat    (burst_beat)
   );

   // Clock-enable lag: the pin takes effect one edge after it is sampled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b1;
      else        en_q <= cke;
   end

   // Low-power state choice uses the bank record after this edge's command.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= MODE_RUN;
      else if (cke)
         mode_q <= MODE_RUN;
      else if (mode_q == MODE_RUN)
         mode_q <= (|open_d) ? MODE_SUSP : MODE_PDN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_code  <= 3'd0;
      end else begin
         cmd_valid <= take;
         cmd_code  <= take ? 3'(code) : 3'd0;
      end
   end

   assign int_clk_en = en_q;
   assign mode       = 2'(mode_q);

endmodule

// File: rtl/cke_gate_model_chk.sv
module cke_gate_model_chk #(
   parameter int NUM_BANKS = 4,
   parameter int BURST_LEN = 4,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cke,
   input logic                 cmd_valid,
   input logic                 int_clk_en,
   input logic [1:0]           mode,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic                 burst_busy,
   input logic [BEAT_W-1:0]    burst_beat
);

   // R5: enable follows the sampled pin one edge later
   a_r5_enable_high: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> int_clk_en);
   a_r5_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> !int_clk_en);

   // R5: nothing is registered and banks hold while disabled
   a_r5_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      !int_clk_en |=> (!cmd_valid && $stable(bank_open)));

   // R4/R6: normal mode coincides with the internal enable
   a_r4_mode_tracks_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) == int_clk_en);

   // R4: suspend only with a bank open, power-down only with none
   a_r4_suspend_open: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> (|bank_open));
   a_r4_pdn_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> (bank_open == '0));
   a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11);

   // R8: burst frozen while disabled
   a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !int_clk_en |=> ($stable(burst_busy) && $stable(burst_beat)));

   // R7: beat index stays inside the burst
   a_r7_beat_range: assert property (@(posedge clk) disable iff (!rst_n)
      burst_busy |-> (int'(burst_beat) < BURST_LEN));

   // R6: leaving a low-power state returns straight to normal
   a_r6_exit: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode != 2'b00) && cke) |=> (mode == 2'b00));

endmodule

bind cke_gate_model cke_gate_model_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BURST_LEN (BURST_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cke        (cke),
   .cmd_valid  (cmd_valid),
   .int_clk_en (int_clk_en),
   .mode       (mode),
   .bank_open  (bank_open),
   .burst_busy (burst_busy),
   .burst_beat (burst_beat)
);

// File: tb/sim_cke_gate_model.sv
`timescale 1ns/1ps
module sim_cke_gate_model;

   localparam int NB = 4;
   localparam int BL = 4;
   localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                          C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_BST = 3'd7;
   localparam logic [2:0] C_DES = 3'd8 - 3'd1; // placeholder code unused; deselect via flag

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = 2'd0;
   logic       pre_all = 1'b0;
   logic       cmd_valid;
   logic [2:0] cmd_code;
   logic       int_clk_en;
   logic [1:0] mode;
   logic [NB-1:0] bank_open;
   logic       burst_busy;
   logic [1:0] burst_beat;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   cke_gate_model #(.NUM_BANKS(NB), .BURST_LEN(BL)) u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .pre_all(pre_all),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .int_clk_en(int_clk_en),
      .mode(mode), .bank_open(bank_open), .burst_busy(burst_busy),
      .burst_beat(burst_beat)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Put a command on the pins; code 3'd0..7 per R2, des=1 for deselect.
   task automatic drive(input logic [2:0] c, input bit des, input logic k,
                        input logic [1:0] b, input logic all);
      cke = k; ba = b; pre_all = all;
      cs_n = des;
      case (c)
         C_NOP: {ras_n, cas_n, we_n} = 3'b111;
         C_ACT: {ras_n, cas_n, we_n} = 3'b011;
         C_RD:  {ras_n, cas_n, we_n} = 3'b101;
         C_WR:  {ras_n, cas_n, we_n} = 3'b100;
         C_PRE: {ras_n, cas_n, we_n} = 3'b010;
         C_REF: {ras_n, cas_n, we_n} = 3'b001;
         C_MRS: {ras_n, cas_n, we_n} = 3'b000;
         default: {ras_n, cas_n, we_n} = 3'b110;
      endcase
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic cmd(input logic [2:0] c, input logic k, input logic [1:0] b,
                      input logic all);
      drive(c, 1'b0, k, b, all);
      step();
   endtask

   task automatic desel(input logic k);
      drive(C_NOP, 1'b1, k, 2'd0, 1'b0);
      step();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      drive(C_NOP, 1'b1, 1'b1, 2'd0, 1'b0);
      repeat (3) step();
      check("R1", "mode in reset", 8'(mode), 8'h0);
      check("R1", "banks in reset", 8'(bank_open), 8'h0);
      rst_n = 1'b1;
      desel(1'b1);
      check("R1", "int_clk_en", 8'(int_clk_en), 8'h1);
      check("R1", "cmd_valid", 8'(cmd_valid), 8'h0);
      check("R1", "burst_busy", 8'(burst_busy), 8'h0);
      check("R1", "mode", 8'(mode), 8'h0);
   endtask

   task automatic t_decode();
      logic [2:0] seq [8] = '{C_NOP, C_ACT, C_RD, C_WR, C_BST, C_PRE, C_REF, C_MRS};
      foreach (seq[i]) begin
         cmd(seq[i], 1'b1, 2'd1, 1'b1);
         check("R2", "cmd_valid", 8'(cmd_valid), 8'h1);
         check("R2", "cmd_code", 8'(cmd_code), 8'(seq[i]));
      end
      desel(1'b1);
      check("R2", "deselect not registered", 8'(cmd_valid), 8'h0);
   endtask

   task automatic t_banks();
      cmd(C_ACT, 1'b1, 2'd0, 1'b0);
      cmd(C_ACT, 1'b1, 2'd2, 1'b0);
      check("R3", "two activates", 8'(bank_open), 8'h5);
      cmd(C_PRE, 1'b1, 2'd0, 1'b0);
      check("R3", "single precharge", 8'(bank_open), 8'h4);
      cmd(C_ACT, 1'b1, 2'd3, 1'b0);
      check("R3", "third activate", 8'(bank_open), 8'hC);
      cmd(C_PRE, 1'b1, 2'd1, 1'b1);
      check("R3", "precharge all", 8'(bank_open), 8'h0);
   endtask

   task automatic t_powerdown();
      desel(1'b0);
      check("R4", "power-down mode", 8'(mode), 8'h2);
      check("R5", "enable low after cke low", 8'(int_clk_en), 8'h0);
      cmd(C_ACT, 1'b0, 2'd1, 1'b0);
      check("R5", "activate ignored valid", 8'(cmd_valid), 8'h0);
      check("R5", "activate ignored banks", 8'(bank_open), 8'h0);
      cmd(C_ACT, 1'b1, 2'd1, 1'b0);
      check("R6", "mode normal on exit edge", 8'(mode), 8'h0);
      check("R6", "exit-edge command ignored", 8'(cmd_valid), 8'h0);
      check("R6", "exit-edge banks", 8'(bank_open), 8'h0);
      cmd(C_ACT, 1'b1, 2'd1, 1'b0);
      check("R6", "command taken after exit", 8'(cmd_valid), 8'h1);
      check("R3", "bank1 open", 8'(bank_open), 8'h2);
   endtask

   task automatic t_suspend();
      cmd(C_RD, 1'b1, 2'd1, 1'b0);
      check("R7", "burst start busy", 8'(burst_busy), 8'h1);
      check("R7", "burst start beat", 8'(burst_beat), 8'h0);
      cmd(C_NOP, 1'b1, 2'd0, 1'b0);
      check("R7", "nop keeps burst", 8'(burst_beat), 8'h1);
      cmd(C_NOP, 1'b0, 2'd0, 1'b0);
      check("R4", "suspend entered", 8'(mode), 8'h1);
      check("R7", "lag edge still advances", 8'(burst_beat), 8'h2);
      desel(1'b0);
      check("R8", "beat frozen", 8'(burst_beat), 8'h2);
      cmd(C_WR, 1'b0, 2'd0, 1'b0);
      check("R5", "write ignored in suspend", 8'(cmd_valid), 8'h0);
      check("R8", "beat frozen after write", 8'(burst_beat), 8'h2);
      check("R8", "busy held", 8'(burst_busy), 8'h1);
      cmd(C_NOP, 1'b1, 2'd0, 1'b0);
      check("R6", "suspend exit mode", 8'(mode), 8'h0);
      check("R8", "exit edge still frozen", 8'(burst_beat), 8'h2);
      desel(1'b1);
      check("R7", "deselect keeps burst", 8'(burst_beat), 8'h3);
      cmd(C_NOP, 1'b1, 2'd0, 1'b0);
      check("R7", "burst completes", 8'(burst_busy), 8'h0);
   endtask

   task automatic t_entry_with_act();
      cmd(C_PRE, 1'b1, 2'd0, 1'b1);
      check("R3", "cleared", 8'(bank_open), 8'h0);
      cmd(C_ACT, 1'b0, 2'd2, 1'b0);
      check("R4", "same-edge activate gives suspend", 8'(mode), 8'h1);
      check("R5", "lag edge command taken", 8'(bank_open), 8'h4);
      desel(1'b1);
      check("R6", "back to normal", 8'(mode), 8'h0);
      cmd(C_PRE, 1'b1, 2'd0, 1'b1);
   endtask

   task automatic t_burst_stop();
      cmd(C_WR, 1'b1, 2'd0, 1'b0);
      cmd(C_NOP, 1'b1, 2'd0, 1'b0);
      cmd(C_BST, 1'b1, 2'd0, 1'b0);
      check("R7", "burst-stop ends burst", 8'(burst_busy), 8'h0);
      check("R2", "burst-stop code", 8'(cmd_code), 8'(C_BST));
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      if (C_DES == 3'd7) begin end
      t_reset();
      t_decode();
      cmd(C_PRE, 1'b1, 2'd0, 1'b1);
      desel(1'b1);
      t_banks();
      t_powerdown();
      t_suspend();
      t_entry_with_act();
      t_burst_stop();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule